// File: doc/BRIEF.md
# Power Mode and Wakeup Controller

This block sits between a small microcontroller core and the enables of its clocks, oscillators and analog monitors. Software writes a two-bit power mode request. The block then gates the CPU clock and the peripheral clock, and switches the main crystal oscillator, the internal RC oscillator, the brownout detector and the comparators on or off to match the requested mode and the current clock and timer configuration.

While the block is in a low-power mode it watches level-sensitive wake events from the brownout, keyboard, real-time timer, watchdog and comparator units. Each event is filtered through its own enable bits and through the rules of the current mode. A wake from idle returns at once. A wake from either power-down mode restarts the oscillators immediately and holds the CPU clock off for a startup count. That count is longer for a crystal source than for the RC or external sources. When the wake completes, the mode field clears, and a one-cycle pulse tells the core whether to resume through the interrupt path or the reset path.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: A write with `modeWr` high in normal mode loads `modeReq` into the mode field. The encoding is 00 normal, 01 idle, 10 power down and 11 total power down. `modeCur` shows the field. Writes in any other state are ignored, and the field reads 00 after reset.
- R2: In idle, `cpuClkEn` is 0 and `periphClkEn` is 1. The oscillator and monitor enables keep their normal-mode values.
- R3: In idle, a qualified wake event returns the block to normal on the next clock edge, with no startup wait. The completion pulse appears in the same cycle as the return.
- R4: Interrupt sources map to bit positions as follows: `wakeIrq`/`intEn` bit 0 is brownout, bit 1 is keyboard, bit 2 is timer, bit 3 is watchdog and bit 4 is comparator. An interrupt qualifies only when its own `intEn` bit and `globalIntEn` are both 1. Reset sources are `wakeRst`/`rstEn` bit 0 for brownout and bit 1 for watchdog, and a reset qualifies only when its `rstEn` bit is 1.
- R5: In either power-down mode, the CPU and peripheral clocks are off. `mainOscEn` is 1 only when `rtcEn`, `rtcOnXtal` and not `rtcPd` all hold. `rcOscEn` is 1 only when `clkSrcSel` is 01 (RC) and `rtcEn` is 1. Outside power down, `mainOscEn` = (`clkSrcSel`==00) or (`rtcEn` and `rtcOnXtal`), and `rcOscEn` = (`clkSrcSel`==01).
- R6: In total power down, `bodEn` and `cmpEn` are 0. The brownout interrupt, the comparator interrupt and the brownout reset never wake the block. Only the watchdog, keyboard and timer sources can.
- R7: In both power-down modes, watchdog wake sources (interrupt and reset) count only when `wdClkSel` is 1. The comparator interrupt counts only when `cmpPd` is 0, and `cmpEn` equals not `cmpPd` outside total power down.
- R8: After a power-down wake, the oscillator enables return to their normal-mode values on the next cycle. `cpuClkEn` stays 0 for exactly XTAL_WAIT cycles when `clkSrcSel` was 00 at the wake, or RC_WAIT cycles otherwise. It then rises in the same cycle that `modeCur` clears to 00.
- R9: Each completed wake gives exactly one single-cycle pulse, on `wakeRstPulse` when a qualified reset caused it and on `wakeIntPulse` otherwise. A reset and an interrupt qualifying in the same cycle give the reset pulse.
- R10: In normal mode, wake events change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWr | input | 1 | Mode field write strobe |
| modeReq | input | 2 | Requested power mode |
| clkSrcSel | input | 2 | System clock source: 00 crystal, 01 RC, 10/11 external |
| rtcEn | input | 1 | Real-time timer enabled |
| rtcOnXtal | input | 1 | Timer clocked from the crystal oscillator |
| rtcPd | input | 1 | Timer power-down bit |
| wdClkSel | input | 1 | Watchdog clock select; 1 keeps it active in power down |
| cmpPd | input | 1 | Comparator power-down bit |
| globalIntEn | input | 1 | Global interrupt enable |
| intEn | input | 5 | Per-source interrupt enables |
| rstEn | input | 2 | Per-source reset enables |
| wakeIrq | input | 5 | Raw interrupt wake levels |
| wakeRst | input | 2 | Raw reset wake levels |
| modeCur | output | 2 | Current mode field |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| mainOscEn | output | 1 | Main crystal oscillator enable |
| rcOscEn | output | 1 | Internal RC oscillator enable |
| bodEn | output | 1 | Brownout detector enable |
| cmpEn | output | 1 | Comparator enable |
| wakeIntPulse | output | 1 | Wake completed through the interrupt path |
| wakeRstPulse | output | 1 | Wake completed through the reset path |

## Verification
The bench builds the block with XTAL_WAIT = 16 and RC_WAIT = 5 rather than 1024 and 256. With these values, both startup windows complete many times within the run, and an off-by-one in either count shows up as a one-cycle shift of `cpuClkEn` and of the pulse. The odd RC value also separates the two limits clearly. With short waits, the random phase can also land wake events, mode writes and configuration changes inside the wait window, where they must have no effect.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_IDLE = 3'd1,
    ST_PD   = 3'd2,
    ST_TPD  = 3'd3,
    ST_WAIT = 3'd4
  } pwrState_t;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_IDLE = 2'b01;
  localparam logic [1:0] MODE_PD   = 2'b10;
  localparam logic [1:0] MODE_TPD  = 2'b11;

  localparam logic [1:0] SRC_XTAL = 2'b00;
  localparam logic [1:0] SRC_RC   = 2'b01;

  localparam int N_IRQ   = 5;
  localparam int IRQ_BOD = 0;
  localparam int IRQ_KBD = 1;
  localparam int IRQ_RTC = 2;
  localparam int IRQ_WDT = 3;
  localparam int IRQ_CMP = 4;

  localparam int N_RST   = 2;
  localparam int RST_BOD = 0;
  localparam int RST_WDT = 1;

  typedef struct packed {
    logic cntStart;
    logic fire;
    logic fireRst;
  } ctrlStrobe_t;

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_wake_pkg::*;
(
  input  pwrState_t        state,
  input  logic [N_IRQ-1:0] wakeIrq,
  input  logic [N_IRQ-1:0] intEn,
  input  logic             globalIntEn,
  input  logic [N_RST-1:0] wakeRst,
  input  logic [N_RST-1:0] rstEn,
  input  logic             wdClkSel,
  input  logic             cmpPd,
  output logic             wakeHit,
  output logic             wakeIsRst
);

  logic lowPwr;
  logic totalPd;
  logic [N_IRQ-1:0] irqHit;
  logic [N_RST-1:0] rstHit;

  assign lowPwr  = (state == ST_PD) || (state == ST_TPD);
  assign totalPd = (state == ST_TPD);

  // Per-source survival in the power-down modes
  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    logic alive;
    always_comb begin
      alive = 1'b1;
      if (lowPwr) begin
        if (i == IRQ_WDT) alive = wdClkSel;
        if (i == IRQ_CMP) alive = !cmpPd && !totalPd;
        if (i == IRQ_BOD) alive = !totalPd;
      end
    end
    assign irqHit[i] = wakeIrq[i] & intEn[i] & alive;
  end

  for (genvar j = 0; j < N_RST; j++) begin : g_rst
    logic alive;
    always_comb begin
      alive = 1'b1;
      if (lowPwr) begin
        if (j == RST_WDT) alive = wdClkSel;
        if (j == RST_BOD) alive = !totalPd;
      end
    end
    assign rstHit[j] = wakeRst[j] & rstEn[j] & alive;
  end

  assign wakeIsRst = |rstHit;
  assign wakeHit   = wakeIsRst | (globalIntEn & (|irqHit));

endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
  import pwr_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWr,
  input  logic [1:0]  modeReq,
  input  logic        wakeHit,
  input  logic        wakeIsRst,
  input  logic        cntDone,
  output pwrState_t   state,
  output logic [1:0]  modeCur,
  output ctrlStrobe_t strb
);

  pwrState_t  stateNx;
  logic [1:0] modeReg, modeNx;
  logic       kindRst, kindNx;

  always_comb begin
    stateNx = state;
    modeNx  = modeReg;
    kindNx  = kindRst;
    strb    = '0;
    unique case (state)
      ST_RUN: begin
        if (modeWr && modeReq != MODE_RUN) begin
          modeNx = modeReq;
          unique case (modeReq)
            MODE_IDLE: stateNx = ST_IDLE;
            MODE_PD:   stateNx = ST_PD;
            default:   stateNx = ST_TPD;
          endcase
        end
      end
      ST_IDLE: begin
        if (wakeHit) begin
          stateNx      = ST_RUN;
          modeNx       = MODE_RUN;
          strb.fire    = 1'b1;
          strb.fireRst = wakeIsRst;
        end
      end
      ST_PD, ST_TPD: begin
        if (wakeHit) begin
          stateNx       = ST_WAIT;
          kindNx        = wakeIsRst;
          strb.cntStart = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cntDone) begin
          stateNx      = ST_RUN;
          modeNx       = MODE_RUN;
          strb.fire    = 1'b1;
          strb.fireRst = kindRst;
        end
      end
      default: stateNx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      modeReg <= MODE_RUN;
      kindRst <= 1'b0;
    end else begin
      state   <= stateNx;
      modeReg <= modeNx;
      kindRst <= kindNx;
    end
  end

  assign modeCur = modeReg;

  // R1
  run_mode_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (modeReg == MODE_RUN));

  // R10
  run_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !modeWr) |=> (state == ST_RUN));

  // R3
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wakeHit) |=> (state == ST_RUN));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !cntDone) |=> (state == ST_WAIT));

endmodule

// File: rtl/pwr_wake_dp.sv
module pwr_wake_dp
  import pwr_wake_pkg::*;
#(
  parameter int XTAL_WAIT = 1024,
  parameter int RC_WAIT   = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  pwrState_t   state,
  input  ctrlStrobe_t strb,
  input  logic [1:0]  clkSrcSel,
  input  logic        rtcEn,
  input  logic        rtcOnXtal,
  input  logic        rtcPd,
  input  logic        cmpPd,
  output logic        cntDone,
  output logic        cpuClkEn,
  output logic        periphClkEn,
  output logic        mainOscEn,
  output logic        rcOscEn,
  output logic        bodEn,
  output logic        cmpEn,
  output logic        wakeIntPulse,
  output logic        wakeRstPulse
);

  localparam int MAX_WAIT = (XTAL_WAIT > RC_WAIT) ? XTAL_WAIT : RC_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] XTAL_LIM = CNT_W'(XTAL_WAIT);
  localparam logic [CNT_W-1:0] RC_LIM   = CNT_W'(RC_WAIT);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limReg;
  logic             lowPwr;
  logic             rtcXtalKeep;

  // Startup counter, limit picked from the source at the wake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      limReg <= XTAL_LIM;
    end else if (strb.cntStart) begin
      cnt    <= '0;
      limReg <= (clkSrcSel == SRC_XTAL) ? XTAL_LIM : RC_LIM;
    end else if (state == ST_WAIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntDone = (state == ST_WAIT) && (cnt == limReg - 1'b1);

  // Completion pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeIntPulse <= 1'b0;
      wakeRstPulse <= 1'b0;
    end else begin
      wakeIntPulse <= strb.fire & !strb.fireRst;
      wakeRstPulse <= strb.fire & strb.fireRst;
    end
  end

  // Enables per state and configuration
  assign lowPwr      = (state == ST_PD) || (state == ST_TPD);
  assign rtcXtalKeep = rtcEn & rtcOnXtal;

  assign cpuClkEn    = (state == ST_RUN);
  assign periphClkEn = !lowPwr;
  assign mainOscEn   = lowPwr ? (rtcXtalKeep & !rtcPd)
                              : ((clkSrcSel == SRC_XTAL) | rtcXtalKeep);
  assign rcOscEn     = (clkSrcSel == SRC_RC) & (!lowPwr | rtcEn);
  assign bodEn       = (state != ST_TPD);
  assign cmpEn       = (state != ST_TPD) & !cmpPd;

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wakeIntPulse, wakeRstPulse}));

  // R9
  int_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeIntPulse |=> !wakeIntPulse);

  // R9
  rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeRstPulse |=> !wakeRstPulse);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (cnt < limReg));

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int XTAL_WAIT = 1024,
  parameter int RC_WAIT   = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWr,
  input  logic [1:0] modeReq,
  input  logic [1:0] clkSrcSel,
  input  logic       rtcEn,
  input  logic       rtcOnXtal,
  input  logic       rtcPd,
  input  logic       wdClkSel,
  input  logic       cmpPd,
  input  logic       globalIntEn,
  input  logic [4:0] intEn,
  input  logic [1:0] rstEn,
  input  logic [4:0] wakeIrq,
  input  logic [1:0] wakeRst,
  output logic [1:0] modeCur,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       mainOscEn,
  output logic       rcOscEn,
  output logic       bodEn,
  output logic       cmpEn,
  output logic       wakeIntPulse,
  output logic       wakeRstPulse
);

  pwrState_t   state;
  ctrlStrobe_t strb;
  logic        wakeHit;
  logic        wakeIsRst;
  logic        cntDone;

  pwr_wake_qual u_qual (
    .state       (state),
    .wakeIrq     (wakeIrq),
    .intEn       (intEn),
    .globalIntEn (globalIntEn),
    .wakeRst     (wakeRst),
    .rstEn       (rstEn),
    .wdClkSel    (wdClkSel),
    .cmpPd       (cmpPd),
    .wakeHit     (wakeHit),
    .wakeIsRst   (wakeIsRst)
  );

  pwr_wake_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .modeWr    (modeWr),
    .modeReq   (modeReq),
    .wakeHit   (wakeHit),
    .wakeIsRst (wakeIsRst),
    .cntDone   (cntDone),
    .state     (state),
    .modeCur   (modeCur),
    .strb      (strb)
  );

  pwr_wake_dp #(
    .XTAL_WAIT (XTAL_WAIT),
    .RC_WAIT   (RC_WAIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .state        (state),
    .strb         (strb),
    .clkSrcSel    (clkSrcSel),
    .rtcEn        (rtcEn),
    .rtcOnXtal    (rtcOnXtal),
    .rtcPd        (rtcPd),
    .cmpPd        (cmpPd),
    .cntDone      (cntDone),
    .cpuClkEn     (cpuClkEn),
    .periphClkEn  (periphClkEn),
    .mainOscEn    (mainOscEn),
    .rcOscEn      (rcOscEn),
    .bodEn        (bodEn),
    .cmpEn        (cmpEn),
    .wakeIntPulse (wakeIntPulse),
    .wakeRstPulse (wakeRstPulse)
  );

endmodule

// File: tb/pwr_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb;

  localparam int XW = 16;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWr = 0;
  logic [1:0] modeReq = 0;
  logic [1:0] clkSrcSel = 0;
  logic rtcEn = 0, rtcOnXtal = 0, rtcPd = 0, wdClkSel = 0, cmpPd = 0, globalIntEn = 0;
  logic [4:0] intEn = 0, wakeIrq = 0;
  logic [1:0] rstEn = 0, wakeRst = 0;
  logic [1:0] modeCur;
  logic cpuClkEn, periphClkEn, mainOscEn, rcOscEn, bodEn, cmpEn, wakeIntPulse, wakeRstPulse;

  always #2 clk = ~clk;

  pwr_wake_ctrl #(.XTAL_WAIT(XW), .RC_WAIT(RW)) u_dut (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeReq(modeReq), .clkSrcSel(clkSrcSel),
    .rtcEn(rtcEn), .rtcOnXtal(rtcOnXtal), .rtcPd(rtcPd), .wdClkSel(wdClkSel), .cmpPd(cmpPd),
    .globalIntEn(globalIntEn), .intEn(intEn), .rstEn(rstEn), .wakeIrq(wakeIrq), .wakeRst(wakeRst),
    .modeCur(modeCur), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .mainOscEn(mainOscEn),
    .rcOscEn(rcOscEn), .bodEn(bodEn), .cmpEn(cmpEn), .wakeIntPulse(wakeIntPulse),
    .wakeRstPulse(wakeRstPulse)
  );

  // Reference model: 0 run, 1 idle, 2 power down, 3 total power down, 4 startup wait
  int refSt = 0, refMode = 0, refCnt = 0, refLim = XW;
  bit refKindRst = 0, refIntP = 0, refRstP = 0;
  int vecs = 0, fails = 0;
  string phaseTag = "R1";

  function automatic bit refHit(input int st, output bit isRst);
    bit [4:0] im;
    bit [1:0] rm;
    bit lp;
    im = intEn & wakeIrq;
    rm = rstEn & wakeRst;
    lp = (st == 2) || (st == 3);
    if (lp) begin
      if (!wdClkSel) begin im[3] = 0; rm[1] = 0; end
      if (cmpPd || st == 3) im[4] = 0;
      if (st == 3) begin im[0] = 0; rm[0] = 0; end
    end
    isRst = |rm;
    return (globalIntEn && (|im)) || (|rm);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSt = 0; refMode = 0; refCnt = 0; refLim = XW;
      refKindRst = 0; refIntP = 0; refRstP = 0;
    end else begin
      bit hit, isR;
      hit = refHit(refSt, isR);
      refIntP = 0; refRstP = 0;
      case (refSt)
        0: if (modeWr && modeReq != 0) begin refSt = int'(modeReq); refMode = int'(modeReq); end
        1: if (hit) begin refSt = 0; refMode = 0; refIntP = !isR; refRstP = isR; end
        2, 3: if (hit) begin
          refSt = 4; refCnt = 0; refKindRst = isR;
          refLim = (clkSrcSel == 2'b00) ? XW : RW;
        end
        default: begin
          if (refCnt == refLim - 1) begin
            refSt = 0; refMode = 0; refIntP = !refKindRst; refRstP = refKindRst;
          end else refCnt++;
        end
      endcase
    end
  end

  task automatic cmp1(input string nm, input logic act, input bit exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", phaseTag, nm, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit lp;
    lp = (refSt == 2) || (refSt == 3);
    vecs++;
    if (modeCur !== 2'(refMode)) begin
      fails++;
      $display("FAIL %s modeCur: actual %0d expected %0d (t=%0t)", phaseTag, modeCur, refMode, $time);
    end
    cmp1("cpuClkEn", cpuClkEn, refSt == 0);
    cmp1("periphClkEn", periphClkEn, !lp);
    cmp1("mainOscEn", mainOscEn, lp ? (rtcEn && rtcOnXtal && !rtcPd)
                                    : (clkSrcSel == 2'b00 || (rtcEn && rtcOnXtal)));
    cmp1("rcOscEn", rcOscEn, (clkSrcSel == 2'b01) && (!lp || rtcEn));
    cmp1("bodEn", bodEn, refSt != 3);
    cmp1("cmpEn", cmpEn, refSt != 3 && !cmpPd);
    cmp1("wakeIntPulse", wakeIntPulse, refIntP);
    cmp1("wakeRstPulse", wakeRstPulse, refRstP);
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      #1;
      compareAll();
      @(negedge clk);
    end
  endtask

  task automatic quiet();
    modeWr = 0; wakeIrq = 0; wakeRst = 0;
  endtask

  task automatic enter(input logic [1:0] m);
    modeWr = 1; modeReq = m; tick(); modeWr = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    phaseTag = "R1"; tick(2);
    // R10: wake events in normal mode change nothing
    phaseTag = "R10"; intEn = 5'h1f; globalIntEn = 1; rstEn = 2'b11;
    wakeIrq = 5'h1f; wakeRst = 2'b11; tick(3); quiet();
    // R4: enabled interrupt without global enable stays idle
    phaseTag = "R4"; enter(2'b01); intEn = 5'b00010; globalIntEn = 0;
    wakeIrq = 5'b00010; tick(3);
    wakeIrq = 5'b00100; globalIntEn = 1; tick(2); // own enable clear
    // R1: mode writes in idle ignored
    phaseTag = "R1"; modeWr = 1; modeReq = 2'b11; tick(2); modeWr = 0; wakeIrq = 0;
    // R2/R3: idle wake through keyboard interrupt
    phaseTag = "R3"; tick(); wakeIrq = 5'b00010; tick(); quiet(); tick(2);
    // R5/R8: power down on crystal with timer kept on the crystal
    phaseTag = "R5"; clkSrcSel = 2'b00; rtcEn = 1; rtcOnXtal = 1; rtcPd = 0;
    enter(2'b10); tick(3); rtcPd = 1; tick(2); rtcPd = 0;
    phaseTag = "R8"; intEn = 5'b00100; wakeIrq = 5'b00100; tick(); quiet(); tick(XW + 3);
    // R9: power down on RC, reset and interrupt together
    phaseTag = "R9"; clkSrcSel = 2'b01; rtcOnXtal = 0; intEn = 5'h1f; rstEn = 2'b01;
    enter(2'b10); tick(2); wakeIrq = 5'b00001; wakeRst = 2'b01; tick(); quiet(); tick(RW + 3);
    // R6/R7: total power down ignores brownout and comparator sources
    phaseTag = "R6"; clkSrcSel = 2'b10; rstEn = 2'b11; wdClkSel = 0;
    enter(2'b11); wakeIrq = 5'b10001; wakeRst = 2'b01; tick(3);
    phaseTag = "R7"; wakeIrq = 5'b01000; wakeRst = 2'b10; tick(3);
    wdClkSel = 1; tick(); quiet(); tick(RW + 3);
    // R7: comparator interrupt in power down gated by its power-down bit
    cmpPd = 1; enter(2'b10); wakeIrq = 5'b10000; tick(3);
    cmpPd = 0; tick(); quiet(); tick(RW + 3);
    // R9: random phase
    phaseTag = "R9";
    for (int c = 0; c < 6000; c++) begin
      modeWr = ($urandom_range(7) == 0);
      modeReq = 2'($urandom_range(3));
      wakeIrq = ($urandom_range(9) == 0) ? 5'($urandom_range(31)) : 5'b0;
      wakeRst = ($urandom_range(19) == 0) ? 2'($urandom_range(3)) : 2'b0;
      if ($urandom_range(39) == 0) begin
        clkSrcSel = 2'($urandom_range(3)); rtcEn = 1'($urandom_range(1));
        rtcOnXtal = 1'($urandom_range(1)); rtcPd = 1'($urandom_range(1));
        wdClkSel = 1'($urandom_range(1)); cmpPd = 1'($urandom_range(1));
        globalIntEn = ($urandom_range(3) != 0); intEn = 5'($urandom_range(31));
        rstEn = 2'($urandom_range(3));
      end
      tick();
    end
    quiet(); tick(XW + 2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule